// File: doc/BRIEF.md
# Prioritised Memory Transaction Queue

This block sits between the requesters of a memory controller and its per-bank command queues. Transactions of three classes (instruction fetch, data read, data write) arrive on a valid/ready port. Each carries an address, a target bank and an age stamp. The block stores them in arrival order. Each cycle it offers one of them on a valid/ready output port. The choice is made out of order, but only among the few oldest entries.

The choice ranks fetches above reads and reads above writes. Within a class the oldest entry wins. Three kinds of entry are passed over for the cycle:
- an entry whose bank reports a full command queue;
- an entry that would overtake an older entry at the same address when either of the two is a write;
- in strict-FIFO mode, every entry other than the head.

A write that younger traffic has overtaken often enough moves above every class. This keeps a stream of reads from starving it.

Top module: `txn_sched_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `out_valid` is low and `in_ready` is high.
- R2: Kind code 2'b00 is a fetch. An eligible fetch is offered before any eligible read or write.
- R3: Kind code 2'b01 is a read, and codes 2'b10 and 2'b11 are writes. An eligible read is offered before any eligible write that has not been promoted.
- R4: Among eligible entries of the same rank, the one that arrived first is offered.
- R5: Only the `WIN` oldest stored entries are eligible. An entry further back is never offered, whatever its class.
- R6: An entry is ineligible while an older entry with the same address is still stored and either of the two is a write.
- R7: An entry whose bank has its `bank_full` bit set is ineligible in that cycle.
- R8: Each time a younger entry is dequeued ahead of a stored write, that write's bypass count rises, saturating at `STARVE`. A write whose count has reached `STARVE` ranks above fetches.
- R9: While `fifo_mode` is high, only the oldest entry can be offered, and only if its bank is not full.
- R10: `in_ready` is low exactly when `DEPTH` entries are stored. An enqueue and a dequeue in the same cycle both take effect.
- R11: A dequeue removes only the offered entry, and the remaining entries keep their relative order. A blocked oldest entry does not stop younger eligible ones from leaving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | Strict in-order mode |
| in_valid | input | 1 | Incoming transaction present |
| in_ready | output | 1 | Queue can accept a transaction |
| in_kind | input | 2 | Class: 00 fetch, 01 read, 1x write |
| in_addr | input | AW | Transaction address |
| in_bank | input | log2(BANKS) | Target bank |
| in_age | input | TW | Age stamp, carried through |
| bank_full | input | BANKS | Per-bank command queue full |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | Bank queues take the offered transaction |
| out_kind | output | 2 | Class of the offered transaction |
| out_addr | output | AW | Address of the offered transaction |
| out_bank | output | log2(BANKS) | Bank of the offered transaction |
| out_age | output | TW | Age stamp of the offered transaction |

## Verification
The bench builds the queue with a depth of 6, a window of 3, four banks, a 3-bit address and a promotion limit of 2. With these values the queue fills within a handful of cycles, so the full-queue stall and simultaneous enqueue/dequeue occur often. The narrow address space makes same-address conflicts frequent. The small window means entries regularly sit just outside eligibility. The low promotion limit lets write promotion fire many times while reads and fetches keep arriving.

// File: rtl/txn_sched_queue.sv
module txn_sched_queue #(
  parameter int DEPTH  = 8,
  parameter int WIN    = 4,
  parameter int AW     = 32,
  parameter int TW     = 8,
  parameter int BANKS  = 8,
  parameter int STARVE = 4
)(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fifo_mode,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [1:0]                           in_kind,
  input  logic [AW-1:0]                        in_addr,
  input  logic [((BANKS>1)?$clog2(BANKS):1)-1:0] in_bank,
  input  logic [TW-1:0]                        in_age,
  input  logic [BANKS-1:0]                     bank_full,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [1:0]                           out_kind,
  output logic [AW-1:0]                        out_addr,
  output logic [((BANKS>1)?$clog2(BANKS):1)-1:0] out_bank,
  output logic [TW-1:0]                        out_age
);
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(STARVE + 1);

  logic [1:0]    q_kind [DEPTH];
  logic [AW-1:0] q_addr [DEPTH];
  logic [BW-1:0] q_bank [DEPTH];
  logic [TW-1:0] q_age  [DEPTH];
  logic [SW-1:0] q_skip [DEPTH];
  logic [CW-1:0] count;

  logic [1:0]    n_kind [DEPTH];
  logic [AW-1:0] n_addr [DEPTH];
  logic [BW-1:0] n_bank [DEPTH];
  logic [TW-1:0] n_age  [DEPTH];
  logic [SW-1:0] n_skip [DEPTH];

  logic [DEPTH-1:0] haz, elig;
  logic [1:0]       lvl [DEPTH];
  logic [IW-1:0]    sel;
  logic             found;
  logic             enq, deq;

  assign in_ready = count < CW'(DEPTH);
  assign enq      = in_valid && in_ready;
  assign deq      = found && out_ready;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      haz[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && q_addr[j] == q_addr[i] && (q_kind[i][1] || q_kind[j][1]))
          haz[i] = 1'b1;
      elig[i] = (CW'(i) < count) && (i < WIN) && !bank_full[q_bank[i]] &&
                !haz[i] && (!fifo_mode || i == 0);
      if (q_kind[i][1] && q_skip[i] == SW'(STARVE)) lvl[i] = 2'd0;
      else if (q_kind[i] == 2'b00)                  lvl[i] = 2'd1;
      else if (q_kind[i] == 2'b01)                  lvl[i] = 2'd2;
      else                                          lvl[i] = 2'd3;
    end
  end

  always_comb begin
    logic [1:0] best;
    found = 1'b0;
    best  = 2'd3;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (elig[i] && (!found || lvl[i] < best)) begin
        found = 1'b1;
        best  = lvl[i];
        sel   = IW'(i);
      end
  end

  assign out_valid = found;
  assign out_kind  = q_kind[sel];
  assign out_addr  = q_addr[sel];
  assign out_bank  = q_bank[sel];
  assign out_age   = q_age[sel];

  always_comb begin
    logic [CW-1:0] wpos;
    int src;
    wpos = count - CW'(deq);
    for (int i = 0; i < DEPTH; i++) begin
      src = (deq && IW'(i) >= sel && i < DEPTH - 1) ? i + 1 : i;
      n_kind[i] = q_kind[src];
      n_addr[i] = q_addr[src];
      n_bank[i] = q_bank[src];
      n_age[i]  = q_age[src];
      n_skip[i] = q_skip[src];
      if (deq && IW'(i) < sel && q_kind[i][1] && q_skip[i] != SW'(STARVE))
        n_skip[i] = q_skip[i] + 1'b1;
      if (enq && CW'(i) == wpos) begin
        n_kind[i] = in_kind;
        n_addr[i] = in_addr;
        n_bank[i] = in_bank;
        n_age[i]  = in_age;
        n_skip[i] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CW'(enq) - CW'(deq);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      q_kind[i] <= n_kind[i];
      q_addr[i] <= n_addr[i];
      q_bank[i] <= n_bank[i];
      q_age[i]  <= n_age[i];
      q_skip[i] <= n_skip[i];
    end
  end
endmodule

// File: rtl/txn_sched_queue_chk.sv
module txn_sched_queue_chk #(
  parameter int DEPTH = 8,
  parameter int WIN   = 4,
  parameter int BANKS = 8,
  parameter int BW    = 3,
  parameter int IW    = 3,
  parameter int CW    = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BW-1:0]    out_bank,
  input logic [BANKS-1:0] bank_full,
  input logic [IW-1:0]    sel,
  input logic [CW-1:0]    count
);
  p_empty_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(sel) < WIN) && (int'(sel) < int'(count)));

  p_bank_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bank_full[out_bank]);

  p_fifo_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && out_valid) |-> sel == '0);

  p_count_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=>
      int'(count) == int'($past(count)) + 1);

  p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
endmodule

bind txn_sched_queue txn_sched_queue_chk #(
  .DEPTH(DEPTH), .WIN(WIN), .BANKS(BANKS), .BW(BW), .IW(IW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_bank(out_bank), .bank_full(bank_full), .sel(sel), .count(count)
);

// File: tb/sim_txn_sched_queue.sv
module sim_txn_sched_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6, WIN = 3, AW = 3, TW = 8, BANKS = 4, STARVE = 2;
  localparam int BW = 2;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_kind = '0;
  logic [AW-1:0] in_addr = '0;
  logic [BW-1:0] in_bank = '0;
  logic [TW-1:0] in_age = '0;
  logic [BANKS-1:0] bank_full = '0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [AW-1:0] out_addr;
  logic [BW-1:0] out_bank;
  logic [TW-1:0] out_age;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_sched_queue #(.DEPTH(DEPTH), .WIN(WIN), .AW(AW), .TW(TW), .BANKS(BANKS), .STARVE(STARVE)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_bank(in_bank), .in_age(in_age),
    .bank_full(bank_full), .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_bank(out_bank), .out_age(out_age));

  typedef struct { int kind; int addr; int bank; int age; int skip; } ent_t;
  ent_t mq[$];
  int checks = 0, fails = 0;
  int stamp = 0;
  bit done = 1'b0;

  function automatic bit is_wr(int k); return k >= 2; endfunction

  function automatic int model_pick(output string tag);
    int idx = -1, best = 9;
    tag = "R4";
    for (int i = 0; i < mq.size() && i < WIN; i++) begin
      bit blocked = 1'b0;
      int rank;
      if (fifo_mode && i > 0) break;
      if (bank_full[mq[i].bank]) continue;
      for (int j = 0; j < i; j++)
        if (mq[j].addr == mq[i].addr && (is_wr(mq[i].kind) || is_wr(mq[j].kind))) blocked = 1'b1;
      if (blocked) continue;
      if (is_wr(mq[i].kind) && mq[i].skip >= STARVE) rank = 0;
      else if (mq[i].kind == 0) rank = 1;
      else if (mq[i].kind == 1) rank = 2;
      else rank = 3;
      if (rank < best) begin best = rank; idx = i; end
    end
    if (idx >= 0) begin
      if (fifo_mode) tag = "R9";
      else if (best == 0) tag = "R8";
      else if (best == 1) tag = "R2";
      else if (best == 2) tag = "R3";
      else tag = "R4";
    end
    return idx;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit iv, int kind, int addr, int bank, bit ordy, logic [BANKS-1:0] bf, bit fm);
    string tag;
    int idx;
    bit exp_rdy;
    @(negedge clk);
    in_valid = iv; in_kind = 2'(kind); in_addr = AW'(addr); in_bank = BW'(bank);
    in_age = TW'(stamp); out_ready = ordy; bank_full = bf; fifo_mode = fm;
    #1;
    idx = model_pick(tag);
    exp_rdy = mq.size() < DEPTH;
    check(in_ready == exp_rdy, "R10", "in_ready", int'(in_ready), int'(exp_rdy));
    check(out_valid == (idx >= 0), "R5 R6 R7 R11", "out_valid", int'(out_valid), int'(idx >= 0));
    if (out_valid && idx >= 0) begin
      check(int'(out_age) == mq[idx].age, tag, "out_age", int'(out_age), mq[idx].age);
      check(int'(out_addr) == mq[idx].addr && int'(out_kind) == mq[idx].kind &&
            int'(out_bank) == mq[idx].bank, "R11", "out_fields", int'(out_addr), mq[idx].addr);
    end
    if (idx >= 0 && ordy) begin
      for (int j = 0; j < idx; j++)
        if (is_wr(mq[j].kind) && mq[j].skip < STARVE) mq[j].skip++;
      mq.delete(idx);
    end
    if (iv && exp_rdy) begin
      ent_t e;
      e.kind = kind; e.addr = addr; e.bank = bank; e.age = stamp % (1 << TW); e.skip = 0;
      mq.push_back(e);
      stamp++;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYC, MAX_CYC);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R10: fill without draining, then stall on full
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 2 - (i % 3), i % 8, i % BANKS, 1'b0, '0, 1'b0);
    // R2 R3 R4: drain in priority order
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 0, 0, 0, 1'b1, '0, 1'b0);
    // R6: write then read to the same address, read must wait
    step(1'b1, 2, 5, 0, 1'b0, '0, 1'b0);
    step(1'b1, 1, 5, 1, 1'b0, '0, 1'b0);
    step(1'b0, 0, 0, 0, 1'b1, 4'b0001, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 1'b1, '0, 1'b0);
    // R8: a write overtaken by a read stream
    step(1'b1, 2, 1, 0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 12; i++) step(1'b1, i % 2, 2 + (i % 4), 1 + (i % 3), 1'b1, '0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 0, 1'b1, '0, 1'b0);

    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 2500; c++) begin
        bit fm = (ph == 3) || (ph == 6 && c % 50 < 20);
        int bfp = (ph == 2 || ph == 5) ? 40 : 10;
        logic [BANKS-1:0] bf;
        int kind;
        for (int b = 0; b < BANKS; b++) bf[b] = ($urandom_range(99) < bfp);
        kind = (ph == 4) ? (($urandom_range(9) < 6) ? 0 + $urandom_range(1) : 2)
                         : $urandom_range(3);
        step($urandom_range(99) < ((ph % 2) ? 80 : 50), kind, $urandom_range(7),
             $urandom_range(BANKS-1), $urandom_range(99) < ((ph == 1) ? 30 : 70), bf, fm);
      end
    end
    for (int i = 0; i < 20; i++) step(1'b0, 0, 0, 0, 1'b1, '0, 1'b0);
    summary();
  end
endmodule